// File: doc/BRIEF.md
# Serial Control Register Port

This block is the slave end of a four-wire host port: an enable, a shift clock, a serial data input and a serial data output. Through this port a microcontroller reads and writes a bank of six 8-bit control registers. Every access is one 12-bit frame, sent MSB first. The frame carries a direction flag, a 3-bit register address and one data byte. The port inputs are asynchronous to the block. They pass through a synchronizer into the system clock `clk_i`, and the shift-clock edges are found by oversampling, so the whole block runs in one clock domain.

All six registers appear at once on a flat parallel bus so that the rest of the chip can use them. Three power-control inputs are also synchronized and decoded. When all three are low (full standby), the bank is cleared. In the other standby state the bank keeps its contents. Bits that have no function are held at zero. The serial output is a data bit plus an output-enable; the pad puts the line in high impedance while the enable is low.

Top module: `ctl_port`

## Requirements
- R1: A frame is shifted in on rising edges of `sck_i` while `en_i` is high. The first bit is the direction (1 = read, 0 = write), then address bits 2..0, then data bits 7..0.
- R2: A write frame changes the addressed register only when its twelfth bit is received. The new value appears on `regs_o[8*a +: 8]` four `clk_i` cycles after that rising edge of `sck_i`.
- R3: If `en_i` falls before the twelfth bit, the frame is discarded and the next frame starts from its first bit. Rising edges after the twelfth bit are ignored until `en_i` falls.
- R4: Addresses 0 to 5 select registers 0 to 5. Writes to addresses 6 and 7 change nothing, and reads from them return 0x00.
- R5: On a read frame, `sdo_oe_o` rises three cycles after the fourth rising edge and `sdo_o` shows data bit 7. Each later rising edge moves to the next lower bit, also after three cycles. The twelfth edge, or `en_i` falling, drops `sdo_oe_o` three cycles later.
- R6: While `sdo_oe_o` is low, `sdo_o` is 0.
- R7: Register 2 bits 3..0, and bits 2..0 of registers 3 and 4, always read 0 and cannot be written. All other bits of registers 0 to 5 are writable, including register 5 bits 6..4.
- R8: After `rst_ni` is asserted, all registers are 0x00 and `sdo_oe_o` is low.
- R9: When `pwr_run_i`, `pwr_mod_i` and `pwr_dem_i` are all 0, the whole bank is 0x00 from the third cycle on. Writes have no effect for as long as that state lasts.
- R10: Every other combination of the power inputs keeps the register contents, including `pwr_run_i`=0, `pwr_mod_i`=1, `pwr_dem_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the port |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Frame enable from the host, active high |
| sck_i | input | 1 | Shift clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial read data |
| sdo_oe_o | output | 1 | Output-enable for the serial data pad |
| pwr_run_i | input | 1 | Power control: 0 selects standby |
| pwr_mod_i | input | 1 | Power control for the transmit side |
| pwr_dem_i | input | 1 | Power control for the receive side |
| regs_o | output | 48 | Registers 0 to 5, register n at bits 8n+7..8n |

## Verification
The results have fixed delays, counted from the `clk_i` cycle in which the bench changes a pin. A committed write shows on `regs_o` four cycles after the twelfth rising edge. The output-enable and each read bit change three cycles after the edge that causes them. A change of the power inputs or a fall of `en_i` takes effect three cycles later. The bench schedules each expected change in a queue, tagged with the cycle in which it is due. On every falling edge of `clk_i` it applies the entries that have come due and compares all outputs with that model. It also samples each read bit the way a host would, just before the next rising edge.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned NUM_REGS = 6;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned SYNC_N   = 2;

  // writable bits per register; unimplemented addresses have none
  function automatic logic [REG_W-1:0] keep_mask(int unsigned idx);
    case (idx)
      0, 1, 5: keep_mask = 8'hFF;
      2:       keep_mask = 8'hF0;
      3, 4:    keep_mask = 8'hF8;
      default: keep_mask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe <= '0;
    else         pipe <= {pipe[STAGES-2:0], d_i};
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/ctl_frame.sv
module ctl_frame #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          en_i,
  input  logic          sdi_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_vld_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          sdo_o,
  output logic          sdo_oe_o
);
  localparam int unsigned HDR = 1 + AW;
  localparam int unsigned FL  = HDR + DW;
  localparam int unsigned CW  = $clog2(FL + 1);
  localparam logic [CW-1:0] C_HDR_LAST = CW'(HDR - 1);
  localparam logic [CW-1:0] C_HDR      = CW'(HDR);
  localparam logic [CW-1:0] C_LAST     = CW'(FL - 1);
  localparam logic [CW-1:0] C_FULL     = CW'(FL);

  logic [FL-2:0] sh;
  logic [CW-1:0] cnt;
  logic [DW-1:0] osh;
  logic          oe, sck_d, rise;

  assign rise      = sck_i & ~sck_d;
  assign rd_addr_o = {sh[AW-2:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh        <= '0;
      cnt       <= '0;
      osh       <= '0;
      oe        <= 1'b0;
      sck_d     <= 1'b0;
      wr_vld_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      sck_d    <= sck_i;
      wr_vld_o <= 1'b0;
      if (!en_i) begin
        cnt <= '0;
        oe  <= 1'b0;
        osh <= '0;
      end else if (rise && cnt < C_FULL) begin
        sh  <= {sh[FL-3:0], sdi_i};
        cnt <= cnt + 1'b1;
        if (cnt == C_HDR_LAST) begin
          if (sh[HDR-2]) begin  // read flag
            oe  <= 1'b1;
            osh <= rd_data_i;
          end
        end else if (cnt == C_LAST) begin
          oe  <= 1'b0;
          osh <= '0;
          if (!sh[FL-2]) begin
            wr_vld_o  <= 1'b1;
            wr_addr_o <= sh[FL-3 -: AW];
            wr_data_o <= {sh[DW-2:0], sdi_i};
          end
        end else if (cnt >= C_HDR) begin
          osh <= {osh[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign sdo_o    = osh[DW-1];
  assign sdo_oe_o = oe;
endmodule

// File: rtl/ctl_bank.sv
module ctl_bank
  import ctl_port_pkg::*;
#(
  parameter int unsigned NR = NUM_REGS,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = REG_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           wr_vld_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic [AW-1:0]  rd_addr_i,
  output logic [DW-1:0]  rd_data_o,
  output logic [NR*DW-1:0] regs_o
);
  logic [DW-1:0] r [NR];

  for (genvar g = 0; g < NR; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   r[g] <= '0;
      else if (clr_i)                                r[g] <= '0;
      else if (wr_vld_i && wr_addr_i == AW'(g))      r[g] <= wr_data_i & keep_mask(g);
    end
    assign regs_o[g*DW +: DW] = r[g];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NR; i++)
      if (rd_addr_i == AW'(i)) rd_data_o = r[i];
  end
endmodule

// File: rtl/ctl_port.sv
module ctl_port
  import ctl_port_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic                      sck_i,
  input  logic                      sdi_i,
  output logic                      sdo_o,
  output logic                      sdo_oe_o,
  input  logic                      pwr_run_i,
  input  logic                      pwr_mod_i,
  input  logic                      pwr_dem_i,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  logic [5:0]        sync_q;
  logic              sck_s, en_s, sdi_s, run_s, mod_s, dem_s, clr_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [REG_W-1:0]  rd_data, wr_data;
  logic              wr_vld;

  ctl_sync #(.W(6), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, en_i, sdi_i, pwr_run_i, pwr_mod_i, pwr_dem_i}),
    .q_o   (sync_q)
  );

  assign {sck_s, en_s, sdi_s, run_s, mod_s, dem_s} = sync_q;
  assign clr_s = ~run_s & ~mod_s & ~dem_s;  // full standby only

  ctl_frame #(.AW(ADDR_W), .DW(REG_W)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_i    (sck_s),
    .en_i     (en_s),
    .sdi_i    (sdi_s),
    .rd_data_i(rd_data),
    .rd_addr_o(rd_addr),
    .wr_vld_o (wr_vld),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o)
  );

  ctl_bank #(.NR(NUM_REGS), .AW(ADDR_W), .DW(REG_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_s),
    .wr_vld_i (wr_vld),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data),
    .regs_o   (regs_o)
  );
endmodule

// File: rtl/ctl_port_chk.sv
module ctl_port_chk
  import ctl_port_pkg::*;
(
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      en_s_i,
  input logic                      clr_s_i,
  input logic                      wr_vld_i,
  input logic [ADDR_W-1:0]         wr_addr_i,
  input logic [REG_W-1:0]          wr_data_i,
  input logic                      sdo_i,
  input logic                      sdo_oe_i,
  input logic [NUM_REGS*REG_W-1:0] regs_i
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
    p_wr_commit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_vld_i && !clr_s_i && wr_addr_i == ADDR_W'(g)
      |=> regs_i[g*REG_W +: REG_W] == ($past(wr_data_i) & keep_mask(g)));

    p_unused_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (regs_i[g*REG_W +: REG_W] & ~keep_mask(g)) == '0);
  end

  p_oob_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_i && wr_addr_i >= ADDR_W'(NUM_REGS) && !clr_s_i |=> $stable(regs_i));

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_s_i |=> regs_i == '0);

  p_retain_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_vld_i && !clr_s_i |=> $stable(regs_i));

  p_oe_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_i |-> $past(en_s_i));

  p_quiet_out_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_i |-> !sdo_i);
endmodule

bind ctl_port ctl_port_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_s_i   (en_s),
  .clr_s_i  (clr_s),
  .wr_vld_i (wr_vld),
  .wr_addr_i(wr_addr),
  .wr_data_i(wr_data),
  .sdo_i    (sdo_o),
  .sdo_oe_i (sdo_oe_o),
  .regs_i   (regs_o)
);

// File: tb/sim_ctl_port.sv
module sim_ctl_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic run_p = 1'b1, mod_p = 1'b0, dem_p = 1'b0;
  logic sdo, sdo_oe;
  logic [47:0] regs;

  ctl_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .pwr_run_i(run_p), .pwr_mod_i(mod_p),
    .pwr_dem_i(dem_p), .regs_o(regs)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit run = 1'b0;
  string cur_req = "R8";

  typedef struct { int due; int kind; int addr; int val; } ev_t;
  ev_t evq[$];
  logic [7:0] m_regs [8];
  logic [7:0] m_sh = '0;
  bit m_oe = 1'b0, m_clr = 1'b0;

  function automatic logic [7:0] bmask(int a);
    case (a)
      0, 1, 5: return 8'hFF;
      2:       return 8'hF0;
      3, 4:    return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction

  task automatic push(int d, int k, int a, int v);
    ev_t e;
    e.due = d; e.kind = k; e.addr = a; e.val = v;
    evq.push_back(e);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // kind: 0 write, 1 clear level, 2 load, 3 shift, 4 release
  function automatic bit in_pass(int pass, int k);
    if (pass == 0) return k == 2;
    if (pass == 1) return k == 1;
    return k != 1 && k != 2;
  endfunction

  always @(negedge clk) begin
    if (run) begin
      for (int pass = 0; pass < 3; pass++) begin
        for (int i = 0; i < evq.size(); ) begin
          if (evq[i].due <= cyc && in_pass(pass, evq[i].kind)) begin
            case (evq[i].kind)
              0: if (!m_clr && evq[i].addr < 6)
                   m_regs[evq[i].addr] = 8'(evq[i].val) & bmask(evq[i].addr);
              1: m_clr = evq[i].val != 0;
              2: begin m_oe = 1'b1; m_sh = (evq[i].addr < 6) ? m_regs[evq[i].addr] : 8'h00; end
              3: m_sh = {m_sh[6:0], 1'b0};
              default: begin m_oe = 1'b0; m_sh = '0; end
            endcase
            evq.delete(i);
          end else i++;
        end
      end
      if (m_clr) for (int i = 0; i < 8; i++) m_regs[i] = '0;
      for (int i = 0; i < 6; i++) chk({cur_req, " regs"}, int'(regs[i*8 +: 8]), int'(m_regs[i]));
      chk({cur_req, "/R5 oe"}, int'(sdo_oe), int'(m_oe));
      chk({cur_req, "/R6 sdo"}, int'(sdo), int'(m_sh[7]));
    end
  end

  task automatic frame(input bit rw, input int a, input int d, input int nbits,
                       output logic [7:0] got);
    logic [11:0] v;
    v = {rw, 3'(a), 8'(d)};
    got = '0;
    @(negedge clk); en = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 1; i <= nbits; i++) begin
      sdi = (i <= 12) ? v[12-i] : 1'b1;
      repeat (4) @(negedge clk);
      if (rw && i >= 5 && i <= 12) got[12-i] = sdo;
      sck = 1'b1;
      if (i == 4 && rw)            push(cyc + 3, 2, a, 0);
      else if (i >= 5 && i <= 11)  push(cyc + 3, 3, 0, 0);
      else if (i == 12) begin
        push(cyc + 3, 4, 0, 0);
        if (!rw) push(cyc + 4, 0, a, d);
      end
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (3) @(negedge clk);
    en = 1'b0;
    push(cyc + 3, 4, 0, 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    logic [7:0] g;
    frame(1'b0, a, d, 12, g);
  endtask

  task automatic rd(int a, output logic [7:0] g);
    frame(1'b1, a, 0, 12, g);
  endtask

  task automatic set_pwr(bit r, bit m, bit d);
    @(negedge clk);
    run_p = r; mod_p = m; dem_p = d;
    push(cyc + 3, 1, 0, int'(!r && !m && !d));
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [7:0] g;
    for (int i = 0; i < 8; i++) m_regs[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run = 1'b1;
    // R8 reset state
    chk("R8 reg0", int'(regs[7:0]), 0);
    chk("R8 all", int'(regs == '0), 1);
    chk("R8 oe", int'(sdo_oe), 0);

    cur_req = "R1";
    wr(0, 'hA5);
    chk("R1 reg0", int'(regs[7:0]), 'hA5);
    cur_req = "R2";
    wr(1, 'h3C);
    chk("R2 reg1", int'(regs[15:8]), 'h3C);
    cur_req = "R7";
    wr(5, 'hFF);
    chk("R7 reg5 test bits writable", int'(regs[47:40]), 'hFF);
    wr(2, 'hFF); chk("R7 reg2", int'(regs[23:16]), 'hF0);
    wr(3, 'hFF); chk("R7 reg3", int'(regs[31:24]), 'hF8);
    wr(4, 'h07); chk("R7 reg4", int'(regs[39:32]), 'h00);
    rd(3, g);    chk("R7 read reg3", int'(g), 'hF8);

    cur_req = "R5";
    rd(0, g); chk("R5 read reg0", int'(g), 'hA5);
    rd(1, g); chk("R5 read reg1", int'(g), 'h3C);
    wr(4, 'h68);
    rd(4, g); chk("R5 read reg4", int'(g), 'h68);

    cur_req = "R4";
    wr(6, 'hFF); wr(7, 'h81);
    chk("R4 oob write", int'(regs[39:0]), int'(40'h68_F8_F0_3C_A5 & 40'hFFFFFFFFFF));
    rd(6, g); chk("R4 read addr6", int'(g), 0);
    rd(7, g); chk("R4 read addr7", int'(g), 0);

    cur_req = "R3";
    frame(1'b0, 1, 'h00, 11, g);
    chk("R3 cut write dropped", int'(regs[15:8]), 'h3C);
    frame(1'b1, 0, 0, 8, g);
    chk("R3 cut read oe low", int'(sdo_oe), 0);
    frame(1'b0, 1, 'h5A, 14, g);
    chk("R3 extra edges ignored", int'(regs[15:8]), 'h5A);
    rd(1, g); chk("R3 read after cut", int'(g), 'h5A);

    cur_req = "R10";
    set_pwr(1'b0, 1'b1, 1'b0);
    chk("R10 standby keep", int'(regs[15:8]), 'h5A);
    set_pwr(1'b0, 1'b0, 1'b1);
    chk("R10 dem only keep", int'(regs[7:0]), 'hA5);
    set_pwr(1'b1, 1'b0, 1'b0);
    chk("R10 run keep", int'(regs[47:40]), 'hFF);

    cur_req = "R9";
    set_pwr(1'b0, 1'b0, 1'b0);
    chk("R9 cleared", int'(regs == '0), 1);
    wr(0, 'h77);
    chk("R9 write blocked", int'(regs[7:0]), 0);
    set_pwr(1'b1, 1'b1, 1'b1);
    wr(0, 'h77);
    chk("R9 write after release", int'(regs[7:0]), 'h77);

    cur_req = "R6";
    repeat (5) @(negedge clk);
    chk("R6 idle sdo", int'(sdo), 0);

    run = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule